// File: doc/BRIEF.md
# Expansion Slot Bus Decoder with Video RAM Banking

This block is the CPU-facing front end of an expansion card that plugs into a slot on a 16-bit, 68000-style bus. The slot offers the card two windows: a small 256-byte window for the board identity and control registers, and a 1 MB window for bulk data. The decoder works out what each access is aimed at and routes it there. It answers identity reads itself. It holds a small bank register that selects which half of a 2 MB video SRAM the data window sees. All other register offsets go to the card's own register file.

Every access starts when the CPU raises one of the two window selects and holds the address, direction, byte strobes and write data steady. The decoder produces a single strobe toward the register file or toward the SRAM arbiter. It then raises a transfer acknowledge and keeps it high until the CPU drops the select. Data-window accesses wait for the video-side arbiter to grant a memory slot. Register accesses complete after a fixed single cycle. The data bus is driven only while the card is selected for a read.

Top module: `xslot_decoder`

## Requirements
- R1: After reset, cpu_ack, cpu_rdata_oe, sram_req, sram_we, rf_rd and rf_wr are low and the bank register holds 0.
- R2: A register-window read at word index 0x7F (byte offsets 0xFE-0xFF) returns the BOARD_ID parameter (default 0xD5A1) and produces no register-file strobe.
- R3: A register-window write at word index 0x7F is acknowledged and has no effect: no register-file strobe, and a later read there still returns BOARD_ID.
- R4: Word index 0x00 of the register window is the bank register. A write with the lower byte strobe (cpu_be[0], data bits 7:0) loads it from cpu_wdata[0]. A write without that strobe leaves it unchanged. A read returns the bank value zero-extended to 16 bits.
- R5: Every other register-window index produces exactly one single-cycle rf_rd or rf_wr pulse. That pulse carries rf_idx equal to the word index, rf_be equal to the strobes and rf_wdata equal to the write data. A read returns the rf_rdata seen in that cycle.
- R6: A data-window access presents sram_addr = {bank, cpu_waddr}, where bank is the most significant bit of a 20-bit word address.
- R7: A data-window access holds sram_req high until sram_gnt is high in the same cycle. The transfer happens in that cycle (read data sampled, write strobed), and cpu_ack rises in the following cycle.
- R8: During the granted cycle, sram_be equals the CPU byte strobes {upper, lower}. sram_wdata equals the write data. sram_we is high only for writes.
- R9: cpu_ack stays high while the select is held, drops in the cycle the select drops, and no second strobe is issued for the same access. The CPU leaves at least one idle cycle between accesses.
- R10: cpu_rdata_oe is high only while a window select is high and cpu_rnw is high.
- R11: A register-window access is acknowledged in the cycle after the select is first seen. If both selects are high, the register window takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_reg | input | 1 | Register/identity window select |
| sel_data | input | 1 | Data window select |
| cpu_waddr | input | 19 | CPU word address, bits 19:1 |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_be | input | 2 | Byte strobes {upper, lower} |
| cpu_wdata | input | 16 | Write data from CPU |
| cpu_rdata | output | 16 | Read data to CPU |
| cpu_rdata_oe | output | 1 | Data bus drive enable |
| cpu_ack | output | 1 | Transfer acknowledge |
| rf_rd | output | 1 | Register file read strobe |
| rf_wr | output | 1 | Register file write strobe |
| rf_idx | output | 7 | Register word index |
| rf_be | output | 2 | Register byte enables |
| rf_wdata | output | 16 | Register write data |
| rf_rdata | input | 16 | Register read data |
| sram_req | output | 1 | Request to SRAM arbiter |
| sram_gnt | input | 1 | Grant from SRAM arbiter |
| sram_addr | output | 20 | SRAM word address |
| sram_we | output | 1 | SRAM write strobe |
| sram_be | output | 2 | SRAM byte enables |
| sram_wdata | output | 16 | SRAM write data |
| sram_rdata | input | 16 | SRAM read data |

## Verification
A corrupted bank register shows up as a flipped top bit of sram_addr on the very next data-window access. It also shows up in the value read back from index 0x00 one cycle after the select. A sequencer stuck in its done state is visible right away: the next access either gets an early acknowledge or never sends a strobe, and the bench sees this as a latency mismatch. A stale read-capture register shows up as wrong cpu_rdata at the acknowledge of the access.

// File: rtl/xslot_pkg.sv
package xslot_pkg;
  typedef enum logic [1:0] {
    RW_ID   = 2'd0,
    RW_BANK = 2'd1,
    RW_RF   = 2'd2
  } regwin_kind_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_DONE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/xslot_regwin.sv
module xslot_regwin
  import xslot_pkg::*;
#(
  parameter int REG_AW = 7,
  parameter int DW     = 16,
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_reg,
  input  logic              idle,
  input  logic              rnw,
  input  logic [REG_AW-1:0] idx,
  input  logic [1:0]        be,
  input  logic [DW-1:0]     wdata,
  output regwin_kind_e      kind,
  output logic [BANK_W-1:0] bank_q,
  output logic              rf_rd,
  output logic              rf_wr,
  output logic [REG_AW-1:0] rf_idx,
  output logic [1:0]        rf_be,
  output logic [DW-1:0]     rf_wdata
);
  localparam logic [REG_AW-1:0] ID_IDX   = '1;
  localparam logic [REG_AW-1:0] BANK_IDX = '0;

  logic              launch;
  logic              bank_en;
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    if (idx == ID_IDX)        kind = RW_ID;
    else if (idx == BANK_IDX) kind = RW_BANK;
    else                      kind = RW_RF;
  end

  assign launch = sel_reg & idle;

  always_comb begin
    bank_en = launch & ~rnw & (kind == RW_BANK) & be[0];
    bank_d  = bank_q;
    if (bank_en) bank_d = wdata[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

  assign rf_wr    = launch & ~rnw & (kind == RW_RF) & (|be);
  assign rf_rd    = launch &  rnw & (kind == RW_RF);
  assign rf_idx   = idx;
  assign rf_be    = be;
  assign rf_wdata = wdata;
endmodule

// File: rtl/xslot_sram_map.sv
module xslot_sram_map #(
  parameter int CPU_AW = 19,
  parameter int SRAM_AW = 20,
  parameter int DW = 16,
  localparam int BANK_W = SRAM_AW - CPU_AW
) (
  input  logic               sel_data,
  input  logic               sel_reg,
  input  logic               idle,
  input  logic               rnw,
  input  logic               gnt,
  input  logic [BANK_W-1:0]  bank,
  input  logic [CPU_AW-1:0]  waddr,
  input  logic [1:0]         be,
  input  logic [DW-1:0]      wdata,
  output logic               req,
  output logic               we,
  output logic [SRAM_AW-1:0] addr,
  output logic [1:0]         sbe,
  output logic [DW-1:0]      swdata
);
  assign req    = sel_data & ~sel_reg & idle;
  assign we     = req & gnt & ~rnw;
  assign addr   = {bank, waddr};
  assign sbe    = be;
  assign swdata = wdata;
endmodule

// File: rtl/xslot_seq.sv
module xslot_seq
  import xslot_pkg::*;
#(
  parameter int DW = 16,
  parameter int BANK_W = 1,
  parameter logic [DW-1:0] BOARD_ID = 16'hD5A1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_reg,
  input  logic              sel_data,
  input  logic              rnw,
  input  logic              gnt,
  input  regwin_kind_e      kind,
  input  logic [BANK_W-1:0] bank,
  input  logic [DW-1:0]     rf_rdata,
  input  logic [DW-1:0]     sram_rdata,
  output logic              idle,
  output logic              ack,
  output logic              oe,
  output logic [DW-1:0]     rdata
);
  seq_state_e    st_q, st_d;
  logic          cap_en;
  logic [DW-1:0] rd_d, rd_q;
  logic          any_sel;

  assign any_sel = sel_reg | sel_data;
  assign idle    = (st_q == SQ_IDLE);

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (sel_reg || (sel_data && gnt)) begin
          st_d   = SQ_DONE;
          cap_en = 1'b1;
        end
      end
      SQ_DONE: if (!any_sel) st_d = SQ_IDLE;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_comb begin
    rd_d = rd_q;
    if (cap_en) begin
      if (sel_reg) begin
        case (kind)
          RW_ID:   rd_d = BOARD_ID;
          RW_BANK: rd_d = {{(DW-BANK_W){1'b0}}, bank};
          default: rd_d = rf_rdata;
        endcase
      end else begin
        rd_d = sram_rdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      rd_q <= '0;
    end else begin
      st_q <= st_d;
      if (cap_en) rd_q <= rd_d;
    end
  end

  assign ack   = (st_q == SQ_DONE) & any_sel;
  assign oe    = any_sel & rnw;
  assign rdata = rd_q;
endmodule

// File: rtl/xslot_decoder.sv
module xslot_decoder
  import xslot_pkg::*;
#(
  parameter int CPU_AW  = 19,
  parameter int SRAM_AW = 20,
  parameter int REG_AW  = 7,
  parameter int DW      = 16,
  parameter logic [15:0] BOARD_ID = 16'hD5A1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sel_reg,
  input  logic               sel_data,
  input  logic [CPU_AW-1:0]  cpu_waddr,
  input  logic               cpu_rnw,
  input  logic [1:0]         cpu_be,
  input  logic [DW-1:0]      cpu_wdata,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_rdata_oe,
  output logic               cpu_ack,
  output logic               rf_rd,
  output logic               rf_wr,
  output logic [REG_AW-1:0]  rf_idx,
  output logic [1:0]         rf_be,
  output logic [DW-1:0]      rf_wdata,
  input  logic [DW-1:0]      rf_rdata,
  output logic               sram_req,
  input  logic               sram_gnt,
  output logic [SRAM_AW-1:0] sram_addr,
  output logic               sram_we,
  output logic [1:0]         sram_be,
  output logic [DW-1:0]      sram_wdata,
  input  logic [DW-1:0]      sram_rdata
);
  localparam int BANK_W = SRAM_AW - CPU_AW;

  regwin_kind_e      kind;
  logic [BANK_W-1:0] bank;
  logic              idle;

  xslot_regwin #(.REG_AW(REG_AW), .DW(DW), .BANK_W(BANK_W)) u_regwin (
    .clk(clk), .rst_n(rst_n), .sel_reg(sel_reg), .idle(idle), .rnw(cpu_rnw),
    .idx(cpu_waddr[REG_AW-1:0]), .be(cpu_be), .wdata(cpu_wdata),
    .kind(kind), .bank_q(bank), .rf_rd(rf_rd), .rf_wr(rf_wr),
    .rf_idx(rf_idx), .rf_be(rf_be), .rf_wdata(rf_wdata)
  );

  xslot_sram_map #(.CPU_AW(CPU_AW), .SRAM_AW(SRAM_AW), .DW(DW)) u_map (
    .sel_data(sel_data), .sel_reg(sel_reg), .idle(idle), .rnw(cpu_rnw),
    .gnt(sram_gnt), .bank(bank), .waddr(cpu_waddr), .be(cpu_be),
    .wdata(cpu_wdata), .req(sram_req), .we(sram_we), .addr(sram_addr),
    .sbe(sram_be), .swdata(sram_wdata)
  );

  xslot_seq #(.DW(DW), .BANK_W(BANK_W), .BOARD_ID(BOARD_ID)) u_seq (
    .clk(clk), .rst_n(rst_n), .sel_reg(sel_reg), .sel_data(sel_data),
    .rnw(cpu_rnw), .gnt(sram_gnt), .kind(kind), .bank(bank),
    .rf_rdata(rf_rdata), .sram_rdata(sram_rdata), .idle(idle),
    .ack(cpu_ack), .oe(cpu_rdata_oe), .rdata(cpu_rdata)
  );
endmodule

// File: rtl/xslot_chk.sv
module xslot_chk #(
  parameter int REG_AW = 7,
  parameter logic [15:0] BOARD_ID = 16'hD5A1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_reg,
  input logic              sel_data,
  input logic [18:0]       cpu_waddr,
  input logic              cpu_rnw,
  input logic [15:0]       cpu_rdata,
  input logic              cpu_ack,
  input logic              rf_rd,
  input logic              rf_wr,
  input logic [REG_AW-1:0] rf_idx,
  input logic              sram_req,
  input logic              sram_gnt,
  input logic              sram_we
);
  assert_grant_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req && sram_gnt) |=> cpu_ack);

  assert_wait_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_req && !sram_gnt) |=> !cpu_ack);

  // R3 and R4: identity and bank offsets never reach the register file
  assert_rf_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr || rf_rd) |-> (rf_idx != '1 && rf_idx != '0));

  assert_rf_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr || rf_rd) |=> !(rf_wr || rf_rd));

  assert_no_restrobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |=> !(rf_wr || rf_rd || sram_we || sram_req));

  assert_id_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ack && cpu_rnw && sel_reg && cpu_waddr[REG_AW-1:0] == '1)
      |-> cpu_rdata == BOARD_ID);
endmodule

bind xslot_decoder xslot_chk #(.REG_AW(REG_AW), .BOARD_ID(BOARD_ID)) u_xslot_chk (
  .clk(clk), .rst_n(rst_n), .sel_reg(sel_reg), .sel_data(sel_data),
  .cpu_waddr(cpu_waddr), .cpu_rnw(cpu_rnw), .cpu_rdata(cpu_rdata),
  .cpu_ack(cpu_ack), .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_idx(rf_idx),
  .sram_req(sram_req), .sram_gnt(sram_gnt), .sram_we(sram_we)
);

// File: tb/test_xslot_decoder.sv
module test_xslot_decoder;
  localparam logic [15:0] ID = 16'hD5A1;

  logic        clk, rst_n;
  logic        sel_reg, sel_data, cpu_rnw, sram_gnt;
  logic [18:0] cpu_waddr;
  logic [1:0]  cpu_be;
  logic [15:0] cpu_wdata, cpu_rdata, rf_wdata, rf_rdata, sram_wdata, sram_rdata;
  logic        cpu_rdata_oe, cpu_ack, rf_rd, rf_wr, sram_req, sram_we;
  logic [6:0]  rf_idx;
  logic [1:0]  rf_be, sram_be;
  logic [19:0] sram_addr;

  int checks = 0;
  int errors = 0;

  xslot_decoder #(.BOARD_ID(ID)) i_xslot_decoder (
    .clk(clk), .rst_n(rst_n), .sel_reg(sel_reg), .sel_data(sel_data),
    .cpu_waddr(cpu_waddr), .cpu_rnw(cpu_rnw), .cpu_be(cpu_be),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rdata_oe(cpu_rdata_oe),
    .cpu_ack(cpu_ack), .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_idx(rf_idx),
    .rf_be(rf_be), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .sram_req(sram_req), .sram_gnt(sram_gnt), .sram_addr(sram_addr),
    .sram_we(sram_we), .sram_be(sram_be), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata)
  );

  // bench models of the register file and the SRAM
  assign rf_rdata   = {9'd0, rf_idx} | 16'hA000;
  assign sram_rdata = sram_addr[15:0] ^ 16'h3C3C;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic        isdata;
    logic        rnw;
    logic [18:0] addr;
    logic [15:0] wdata;
    logic [1:0]  be;
    logic [3:0]  wt;
    logic [15:0] exp_rd;
    logic [19:0] exp_sa;
    logic        exp_rf;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 19'h12345, 16'h0000, 2'b11, 4'd0, 16'h1F79, 20'h12345, 1'b0},
    '{1'b0, 1'b0, 19'h00000, 16'h0001, 2'b01, 4'd0, 16'h0000, 20'h00000, 1'b0},
    '{1'b1, 1'b0, 19'h7FFFF, 16'hBEEF, 2'b10, 4'd3, 16'h0000, 20'hFFFFF, 1'b0},
    '{1'b0, 1'b1, 19'h00000, 16'h0000, 2'b11, 4'd0, 16'h0001, 20'h00000, 1'b0},
    '{1'b0, 1'b1, 19'h0007F, 16'h0000, 2'b11, 4'd0, 16'hD5A1, 20'h00000, 1'b0},
    '{1'b0, 1'b0, 19'h0007F, 16'h1234, 2'b11, 4'd0, 16'h0000, 20'h00000, 1'b0},
    '{1'b0, 1'b0, 19'h00010, 16'hCAFE, 2'b11, 4'd0, 16'h0000, 20'h00000, 1'b1},
    '{1'b0, 1'b1, 19'h00022, 16'h0000, 2'b11, 4'd0, 16'hA022, 20'h00000, 1'b1},
    '{1'b0, 1'b0, 19'h00000, 16'h0000, 2'b10, 4'd0, 16'h0000, 20'h00000, 1'b0},
    '{1'b1, 1'b1, 19'h00000, 16'h0000, 2'b11, 4'd2, 16'h3C3C, 20'h80000, 1'b0},
    '{1'b0, 1'b0, 19'h00000, 16'h0000, 2'b01, 4'd0, 16'h0000, 20'h00000, 1'b0},
    '{1'b1, 1'b1, 19'h00005, 16'h0000, 2'b01, 4'd1, 16'h3C39, 20'h00005, 1'b0},
    '{1'b0, 1'b1, 19'h0007F, 16'h0000, 2'b11, 4'd0, 16'hD5A1, 20'h00000, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v);
    int cyc = 0;
    int n_rf = 0;
    int n_sram = 0;
    logic [19:0] sa = '0;
    logic sw = 1'b0;
    logic [1:0] sb = '0;
    logic [15:0] swd = '0;
    logic [6:0] ri = '0;
    logic [15:0] rwd = '0;
    logic [1:0] rbe = '0;
    logic rwr = 1'b0;
    @(negedge clk);
    sel_reg = !v.isdata; sel_data = v.isdata; cpu_waddr = v.addr;
    cpu_rnw = v.rnw; cpu_wdata = v.wdata; cpu_be = v.be;
    sram_gnt = (v.wt == 0);
    while (1) begin
      #1;
      if (rf_rd || rf_wr) begin n_rf++; ri = rf_idx; rwd = rf_wdata; rbe = rf_be; rwr = rf_wr; end
      if (sram_req && sram_gnt) begin n_sram++; sa = sram_addr; sw = sram_we; sb = sram_be; swd = sram_wdata; end
      @(negedge clk);
      cyc++;
      if (cpu_ack || cyc > 40) break;
      sram_gnt = (cyc >= v.wt);
    end
    if (v.isdata) begin
      check(cyc == v.wt + 1, "R7 latency", cyc, v.wt + 1);
      check(n_sram == 1 && sa == v.exp_sa, "R6 sram_addr", sa, v.exp_sa);
      check(sw == !v.rnw && sb == v.be, "R8 we/be", {sw, sb}, {!v.rnw, v.be});
      if (!v.rnw) check(swd == v.wdata, "R8 wdata", swd, v.wdata);
    end else begin
      check(cyc == 1, "R11 latency", cyc, 1);
      check(n_rf == (v.exp_rf ? 1 : 0), "R5 rf strobe count (R3 none for id)", n_rf, v.exp_rf);
      if (v.exp_rf) begin
        check(ri == v.addr[6:0] && rbe == v.be && rwr == !v.rnw, "R5 rf idx/be/dir",
              {rwr, rbe, ri}, {!v.rnw, v.be, v.addr[6:0]});
        if (!v.rnw) check(rwd == v.wdata, "R5 rf wdata", rwd, v.wdata);
      end
    end
    check(cpu_rdata_oe == v.rnw, "R10 oe while selected", cpu_rdata_oe, v.rnw);
    if (v.rnw) check(cpu_rdata == v.exp_rd, "R2/R4/R5/R7 read data", cpu_rdata, v.exp_rd);
    @(negedge clk);
    check(cpu_ack, "R9 ack held", cpu_ack, 1);
    sel_reg = 0; sel_data = 0; sram_gnt = 0;
    #1;
    check(!cpu_ack && !cpu_rdata_oe, "R9 R10 release", {cpu_ack, cpu_rdata_oe}, 0);
    @(negedge clk);
    check(!cpu_ack && !sram_req && !rf_wr && !rf_rd, "R9 quiet after release",
          {cpu_ack, sram_req, rf_wr, rf_rd}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; sel_reg = 0; sel_data = 0; cpu_waddr = '0; cpu_rnw = 1;
    cpu_be = 2'b11; cpu_wdata = '0; sram_gnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!cpu_ack && !cpu_rdata_oe && !sram_req && !sram_we && !rf_rd && !rf_wr,
          "R1 reset outputs", {cpu_ack, cpu_rdata_oe, sram_req, sram_we, rf_rd, rf_wr}, 0);
    // R1: bank is zero after reset
    run('{1'b0, 1'b1, 19'h00000, 16'h0000, 2'b11, 4'd0, 16'h0000, 20'h00000, 1'b0});
    for (int i = 0; i < NV; i++) run(VECS[i]);
    // R11: both selects high, register window wins (no sram request)
    @(negedge clk);
    sel_reg = 1; sel_data = 1; cpu_waddr = 19'h0007F; cpu_rnw = 1; sram_gnt = 1;
    #1;
    check(!sram_req, "R11 reg precedence", sram_req, 0);
    @(negedge clk);
    check(cpu_ack && cpu_rdata == ID, "R11 precedence read", cpu_rdata, ID);
    sel_reg = 0; sel_data = 0; sram_gnt = 0;
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule